// File: doc/BRIEF.md
# Endpoint FIFO Access Controller

This block sits between a small processor and three USB endpoint byte FIFOs. The processor drives the whole exchange through one command/status byte. It writes the byte to pick an endpoint, to set the direction, to raise a request or to flush a FIFO. It reads the byte back to learn whether the chosen FIFO can be accessed, whether a SETUP command has arrived and whether the host has sent a zero-length packet. Data bytes go through a data port that is addressed by endpoint number.

A transfer is a handshake. The processor sets the endpoint and direction first and then raises the request bit. It waits for the ready flag and then moves bytes. After every accepted byte there is a settle interval of `SETTLE_CYC` clock cycles. During that interval ready is low, and any data access is dropped and latches an error flag. To end a write, the processor drops the direction bit and then the request bit. This commits a packet to the USB side, and the packet is flagged as zero-length when no byte was written. To end a read, the processor raises the direction bit and then drops the request bit. The USB side has simple push and pop ports on every FIFO, plus strobes for SETUP data and for zero-length packets. A USB bus reset returns the register to zero and empties the FIFOs.

Top module: `ep_fifo_bridge`

## Requirements
- R1: Register bits: bit0 request, bit1 direction (1 = processor writes), bit2 flush, bits 4:3 endpoint select, bit5 SETUP flag, bit6 ready, bit7 zero-length flag. A write stores bits 4:0 and they read back unchanged. A written 1 in bit6 or bit5 never shows in the readback.
- R2: Select value 0, 1 or 2 chooses FIFO 0, 1 or 2. Select value 3 chooses nothing: ready stays 0 and data-port accesses are dropped with the error flag set.
- R3: After a write that takes the request bit from 0 to 1, ready becomes 1 exactly `SETTLE_CYC` cycles after that write's clock edge. This happens only when the chosen FIFO has data (direction 0) or has room (direction 1).
- R4: An accepted read returns the head byte of the chosen FIFO on `dat_rdata` and pops it. Ready is 0 for the next `SETTLE_CYC` cycles and the next byte can be taken only after that.
- R5: An accepted write pushes the byte. If direction goes 1→0 while the request is held and the request then drops, `pkt_commit` pulses on the cycle after that last register write, carrying the endpoint and `pkt_commit_zero`=1 when no byte was written.
- R6: During a read request, writing direction 1 ends the transfer: ready goes to 0 even if data remains.
- R7: A data access during the settle interval, to an endpoint that is not selected, in the wrong direction, or while ready is 0 is dropped and sets `err`. `err` stays set until a reset.
- R8: While the flush bit is 1, the selected FIFO is emptied from the next clock edge on, whether or not it is ready.
- R9: A USB push marked as SETUP sets bit5. Bit5 stays set until a register write carries 0 in bit5. A SETUP that arrives in the same cycle as such a write leaves it set. Writing 1 never sets it.
- R10: `usb_zlp` sets bit7, which is cleared only by writing 0 to it. A read request on an empty FIFO with bit7 set reads 0x81.
- R11: `usb_rst` returns the register to 0x00, clears `err` and empties all three FIFOs.
- R12: On the USB side, a push into a full FIFO is dropped. Pops return bytes in push order, and `ep_full`/`ep_empty` report each FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| usb_rst | input | 1 | USB bus reset strobe |
| cfg_we | input | 1 | Command/status register write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register readback |
| dat_ep | input | 2 | Endpoint number of the data-port access |
| dat_we | input | 1 | Processor data write strobe |
| dat_re | input | 1 | Processor data read strobe |
| dat_wdata | input | 8 | Processor write byte |
| dat_rdata | output | 8 | Head byte of FIFO `dat_ep` |
| err | output | 1 | Sticky dropped-access flag |
| usb_push | input | 1 | USB-side push strobe |
| usb_push_ep | input | 2 | Endpoint for push |
| usb_push_data | input | 8 | Pushed byte |
| usb_push_setup | input | 1 | Pushed byte belongs to a SETUP command |
| usb_zlp | input | 1 | Host sent a zero-length packet |
| usb_pop | input | 1 | USB-side pop strobe |
| usb_pop_ep | input | 2 | Endpoint for pop |
| usb_pop_data | output | 8 | Head byte of FIFO `usb_pop_ep` |
| ep_full | output | 3 | Per-FIFO full flags |
| ep_empty | output | 3 | Per-FIFO empty flags |
| pkt_commit | output | 1 | Processor finished a write packet |
| pkt_commit_ep | output | 2 | Endpoint of the committed packet |
| pkt_commit_zero | output | 1 | Committed packet has no bytes |

## Verification
The bench builds the block with `DEPTH`=4 and `SETTLE_CYC`=3. With a four-byte FIFO, both the full boundary and the dropped fifth push are reached in a handful of cycles. With a three-cycle settle window, the bench can check the exact cycle where ready rises and can land a data access inside the window. Exercising a FIFO that is both full and requested for writing shows the ready condition and the flush acting together.

// File: rtl/ep_fifo_bridge.sv
module ep_fifo_bridge #(
  parameter int DEPTH      = 8,
  parameter int SETTLE_CYC = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       usb_rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic [1:0] dat_ep,
  input  logic       dat_we,
  input  logic       dat_re,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  output logic       err,
  input  logic       usb_push,
  input  logic [1:0] usb_push_ep,
  input  logic [7:0] usb_push_data,
  input  logic       usb_push_setup,
  input  logic       usb_zlp,
  input  logic       usb_pop,
  input  logic [1:0] usb_pop_ep,
  output logic [7:0] usb_pop_data,
  output logic [2:0] ep_full,
  output logic [2:0] ep_empty,
  output logic       pkt_commit,
  output logic [1:0] pkt_commit_ep,
  output logic       pkt_commit_zero
);
  localparam int AW = $clog2(DEPTH);
  localparam int GW = $clog2(SETTLE_CYC + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(SETTLE_CYC);

  logic          req, tx, clr, scmd, len0;
  logic [1:0]    sel;
  logic          wr_mode, done, wrote;
  logic [GW-1:0] gap;
  logic [3:0]    full4, empty4;
  logic [7:0]    head [4];

  wire req_rise  = cfg_we & cfg_wdata[0] & ~req;
  wire req_fall  = cfg_we & ~cfg_wdata[0] & req;
  wire sel_ok    = sel != 2'b11;
  wire ready     = req & ~done & (gap == '0) & sel_ok &
                   (wr_mode ? ~full4[sel] : ~empty4[sel]);
  wire hit       = dat_ep == sel;
  wire acc_rd    = dat_re & ~dat_we & ready & ~wr_mode & hit;
  wire acc_wr    = dat_we & ~dat_re & ready & wr_mode & hit;
  wire bad       = (dat_re | dat_we) & ~(acc_rd | acc_wr);
  wire setup_evt = usb_push & usb_push_setup;

  assign cfg_rdata    = {len0, ready, scmd, sel, clr, tx, req};
  assign full4[3]     = 1'b1;
  assign empty4[3]    = 1'b1;
  assign head[3]      = 8'h00;
  assign ep_full      = full4[2:0];
  assign ep_empty     = empty4[2:0];
  assign dat_rdata    = head[dat_ep];
  assign usb_pop_data = head[usb_pop_ep];

  always_ff @(posedge clk) begin
    if (!rst_n || usb_rst) begin
      req <= 1'b0; tx <= 1'b0; clr <= 1'b0; sel <= 2'b00;
      scmd <= 1'b0; len0 <= 1'b0;
      wr_mode <= 1'b0; done <= 1'b0; wrote <= 1'b0;
      gap <= '0; err <= 1'b0;
      pkt_commit <= 1'b0; pkt_commit_ep <= 2'b00; pkt_commit_zero <= 1'b0;
    end else begin
      if (cfg_we) begin
        req  <= cfg_wdata[0];
        tx   <= cfg_wdata[1];
        clr  <= cfg_wdata[2];
        sel  <= cfg_wdata[4:3];
        scmd <= (scmd & cfg_wdata[5]) | setup_evt;
        len0 <= (len0 & cfg_wdata[7]) | usb_zlp;
      end else begin
        scmd <= scmd | setup_evt;
        len0 <= len0 | usb_zlp;
      end

      if (req_rise) begin
        wr_mode <= cfg_wdata[1];
        done    <= 1'b0;
      end else if (cfg_we & ~cfg_wdata[0]) begin
        done <= 1'b0;
      end else if (cfg_we & req & (cfg_wdata[1] != wr_mode)) begin
        done <= 1'b1;
      end

      if (req_rise)    wrote <= 1'b0;
      else if (acc_wr) wrote <= 1'b1;

      if (req_rise | acc_rd | acc_wr) gap <= GAP_LOAD;
      else if (gap != '0)             gap <= gap - GW'(1);

      err        <= err | bad;
      pkt_commit <= req_fall & done & wr_mode;
      if (req_fall) begin
        pkt_commit_ep   <= sel;
        pkt_commit_zero <= ~wrote;
      end
    end
  end

  for (genvar e = 0; e < 3; e++) begin : g_ep
    localparam logic [1:0] ID = 2'(e);
    logic [AW:0] wp, rp;
    logic [7:0]  mem [DEPTH];

    wire m_wr  = acc_wr & (sel == ID);
    wire m_rd  = acc_rd & (sel == ID);
    wire u_wr  = usb_push & (usb_push_ep == ID) & ~full4[e] & ~m_wr;
    wire u_rd  = usb_pop & (usb_pop_ep == ID) & ~empty4[e] & ~m_rd;
    wire flush = clr & (sel == ID);

    assign full4[e]  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign empty4[e] = wp == rp;
    assign head[e]   = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
      if (!rst_n || usb_rst || flush) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (m_wr | u_wr) wp <= wp + 1'b1;
        if (m_rd | u_rd) rp <= rp + 1'b1;
      end
    end

    always_ff @(posedge clk)
      if (m_wr | u_wr) mem[wp[AW-1:0]] <= m_wr ? dat_wdata : usb_push_data;

    p_no_push_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
      full4[e] && !(m_rd | u_rd) && !usb_rst && !flush |=> full4[e]);
  end

  p_bus_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    usb_rst |=> (cfg_rdata == 8'h00) && (ep_empty == 3'b111) && !err);

  p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6] |-> cfg_rdata[0]);

  p_gap_after_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd | acc_wr) && !cfg_we |=> !cfg_rdata[6]);

  p_sel3_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[4:3] == 2'b11 |-> !cfg_rdata[6]);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err && !usb_rst |=> err);

  p_setup_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[5] && !usb_rst && !(cfg_we && !cfg_wdata[5]) |=> cfg_rdata[5]);

  p_commit_after_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_commit |-> !cfg_rdata[0] && !cfg_rdata[1]);
endmodule

// File: tb/test_ep_fifo_bridge.sv
module test_ep_fifo_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int S = 3;
  localparam logic [15:0] VEC [7] = '{16'h0000, 16'h0808, 16'h1010, 16'h1818,
                                      16'h0606, 16'hDE1E, 16'h6000};

  logic clk = 1'b0, rst_n = 1'b0, usb_rst = 1'b0;
  logic cfg_we = 1'b0; logic [7:0] cfg_wdata = '0; logic [7:0] cfg_rdata;
  logic [1:0] dat_ep = '0; logic dat_we = 1'b0, dat_re = 1'b0;
  logic [7:0] dat_wdata = '0, dat_rdata; logic err;
  logic usb_push = 1'b0, usb_push_setup = 1'b0, usb_zlp = 1'b0, usb_pop = 1'b0;
  logic [1:0] usb_push_ep = '0, usb_pop_ep = '0;
  logic [7:0] usb_push_data = '0, usb_pop_data;
  logic [2:0] ep_full, ep_empty;
  logic pkt_commit, pkt_commit_zero; logic [1:0] pkt_commit_ep;
  int n_chk = 0, n_fail = 0; bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_fifo_bridge #(.DEPTH(DEPTH), .SETTLE_CYC(S)) i_ep_fifo_bridge (
    .clk, .rst_n, .usb_rst, .cfg_we, .cfg_wdata, .cfg_rdata, .dat_ep, .dat_we,
    .dat_re, .dat_wdata, .dat_rdata, .err, .usb_push, .usb_push_ep,
    .usb_push_data, .usb_push_setup, .usb_zlp, .usb_pop, .usb_pop_ep,
    .usb_pop_data, .ep_full, .ep_empty, .pkt_commit, .pkt_commit_ep,
    .pkt_commit_zero);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask
  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input logic [7:0] v);
    cfg_wdata = v; cfg_we = 1'b1; @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic drd(input logic [1:0] ep);
    dat_ep = ep; dat_re = 1'b1; @(negedge clk); dat_re = 1'b0;
  endtask
  task automatic dwr(input logic [1:0] ep, input logic [7:0] v);
    dat_ep = ep; dat_wdata = v; dat_we = 1'b1; @(negedge clk); dat_we = 1'b0;
  endtask
  task automatic upush(input logic [1:0] ep, input logic [7:0] v, input logic s);
    usb_push_ep = ep; usb_push_data = v; usb_push_setup = s; usb_push = 1'b1;
    @(negedge clk); usb_push = 1'b0; usb_push_setup = 1'b0;
  endtask
  task automatic upop(input logic [1:0] ep);
    usb_pop_ep = ep; usb_pop = 1'b1; @(negedge clk); usb_pop = 1'b0;
  endtask
  task automatic bus_reset; usb_rst = 1'b1; @(negedge clk); usb_rst = 1'b0; endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    chk("R11 reset reg", cfg_rdata, 8'h00);
    chk("R7 reset err", err, 0);
    chk("R12 reset empty", ep_empty, 3'b111);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][15:8]);
      chk("R1 readback", cfg_rdata, VEC[i][7:0]);
    end
    wr(8'h00);

    // read sequence on FIFO0
    upush(0, 8'hA1, 0); upush(0, 8'hA2, 0); upush(0, 8'hA3, 0);
    chk("R12 not empty", ep_empty[0], 0);
    wr(8'h01); cyc(S - 1);
    chk("R3 not yet ready", cfg_rdata, 8'h01);
    cyc(1);
    chk("R3 ready", cfg_rdata, 8'h41);
    dat_ep = 0; #1;
    chk("R4 head", dat_rdata, 8'hA1);
    drd(0);
    chk("R4 gap low", cfg_rdata, 8'h01);
    drd(0);
    chk("R7 early read err", err, 1);
    chk("R7 early read dropped", dat_rdata, 8'hA2);
    cyc(S - 1);
    chk("R4 ready again", cfg_rdata, 8'h41);
    drd(0); cyc(S);
    chk("R4 third byte ready", cfg_rdata, 8'h41);
    chk("R4 third byte", dat_rdata, 8'hA3);
    wr(8'h03);
    chk("R6 read finish", cfg_rdata, 8'h03);
    chk("R6 data kept", ep_empty[0], 0);

    wr(8'h0C); chk("R1 pre reset", cfg_rdata, 8'h0C);
    bus_reset;
    chk("R11 reg zero", cfg_rdata, 8'h00);
    chk("R11 err clear", err, 0);
    chk("R11 fifos empty", ep_empty, 3'b111);

    // write sequence on FIFO1
    wr(8'h0A); wr(8'h0B); cyc(S);
    chk("R3 write ready", cfg_rdata, 8'h4B);
    dwr(1, 8'h55);
    chk("R4 write gap", cfg_rdata, 8'h0B);
    cyc(S);
    chk("R4 write ready again", cfg_rdata, 8'h4B);
    dwr(1, 8'h66); cyc(S);
    wr(8'h09);
    chk("R5 tx drop", cfg_rdata, 8'h09);
    chk("R5 no early commit", pkt_commit, 0);
    wr(8'h08);
    chk("R5 commit", pkt_commit, 1);
    chk("R2 commit ep1", pkt_commit_ep, 2'd1);
    chk("R5 non-zero", pkt_commit_zero, 0);
    cyc(1);
    chk("R5 pulse", pkt_commit, 0);
    usb_pop_ep = 1; #1;
    chk("R12 pop order 0", usb_pop_data, 8'h55);
    upop(1);
    chk("R12 pop order 1", usb_pop_data, 8'h66);
    upop(1);
    chk("R12 drained", ep_empty[1], 1);

    // zero-length write on FIFO2
    wr(8'h12); wr(8'h13); cyc(S);
    chk("R3 ep2 ready", cfg_rdata, 8'h53);
    wr(8'h11); wr(8'h10);
    chk("R5 zlp commit", pkt_commit, 1);
    chk("R2 commit ep2", pkt_commit_ep, 2'd2);
    chk("R5 zero flag", pkt_commit_zero, 1);
    wr(8'h00);

    // zero-length packet from host
    usb_zlp = 1'b1; cyc(1); usb_zlp = 1'b0;
    chk("R10 len0 set", cfg_rdata, 8'h80);
    wr(8'h81); cyc(S);
    chk("R10 read zlp", cfg_rdata, 8'h81);
    wr(8'h00); chk("R10 cleared", cfg_rdata, 8'h00);
    wr(8'h80); chk("R10 no sw set", cfg_rdata, 8'h00);

    // SETUP flag
    upush(0, 8'h77, 1);
    chk("R9 setup set", cfg_rdata, 8'h20);
    wr(8'h20); chk("R9 keep on 1", cfg_rdata, 8'h20);
    cfg_wdata = 8'h00; cfg_we = 1'b1;
    usb_push_ep = 0; usb_push_data = 8'h78; usb_push_setup = 1'b1; usb_push = 1'b1;
    cyc(1);
    cfg_we = 1'b0; usb_push = 1'b0; usb_push_setup = 1'b0;
    chk("R9 set wins", cfg_rdata, 8'h20);
    wr(8'h00); chk("R9 cleared", cfg_rdata, 8'h00);
    wr(8'h20); chk("R9 no sw set", cfg_rdata, 8'h00);

    chk("R8 before flush", ep_empty[0], 0);
    wr(8'h04); cyc(1);
    chk("R8 flushed", ep_empty[0], 1);
    wr(8'h00);

    // full FIFO2
    for (int i = 0; i < 5; i++) upush(2, 8'h10 + 8'(i), 0);
    chk("R12 full", ep_full[2], 1);
    usb_pop_ep = 2;
    for (int i = 0; i < 4; i++) begin
      #1; chk("R12 order", usb_pop_data, 8'h10 + 8'(i));
      upop(2);
    end
    chk("R12 fifth dropped", ep_empty[2], 1);

    // write request on a full FIFO1
    for (int i = 0; i < 4; i++) upush(1, 8'h20 + 8'(i), 0);
    wr(8'h0A); wr(8'h0B); cyc(S + 1);
    chk("R3 no room", cfg_rdata, 8'h0B);
    dwr(1, 8'h99);
    chk("R7 not ready err", err, 1);
    chk("R7 still full", ep_full[1], 1);
    wr(8'h0C); cyc(1);
    chk("R8 flush not ready", ep_empty[1], 1);
    wr(8'h00);

    // wrong direction
    bus_reset;
    upush(0, 8'h44, 0);
    wr(8'h01); cyc(S);
    chk("R3 ready ep0", cfg_rdata, 8'h41);
    dwr(0, 8'h55);
    chk("R7 wrong dir err", err, 1);
    usb_pop_ep = 0; #1;
    chk("R7 wrong dir dropped", usb_pop_data, 8'h44);
    bus_reset;

    // reserved select
    wr(8'h19); cyc(S + 1);
    chk("R2 sel3 never ready", cfg_rdata, 8'h19);
    drd(3);
    chk("R2 sel3 access err", err, 1);
    bus_reset;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule